// File: doc/BRIEF.md
# Core Module Control Register File

This block is the control and status register file of a processor core module. It sits on a simple 32-bit register bus with word addressing. A request asserts `req_i`, and `we_i` selects a write or a read. Writes take effect at the clock edge that samples the request. Read data comes back from a register one cycle later, together with `rvalid_o`.

The register file holds the following:
- Constant identification and status words.
- Two oscillator configuration words. A write to either one is accepted only while a 16-bit key sits in the lock word.
- A control word that drives an LED line and a boot-remap line, and that can also issue a one-cycle system reset request.
- Two flag words, each with its own set address and clear address.
- A free-running reference counter that advances on a tick enable.
- SDRAM and init words that are plain storage.
- An interrupt section with separate IRQ and FIQ enable masks over a raw status vector. The raw vector carries only a software interrupt in bit 0.

Words 32 to 35 are voltage-control placeholders.

Top module: `cm_ctrl_regs`

## Requirements
- R1: Word 0 reads 0x411A3001 and word 4 reads 0x00100000. Words 1 and 32–35 read zero. Writes to any of these have no effect on their readback.
- R2: After reset the registers read as follows: word 2 = 0x01000048, word 7 = 0x0007FEFF, word 8 = 0x00011122, word 9 = 0x00000112. The lock, control, flags, enables, software bit and counter all read zero.
- R3: Word 5 keeps only bits 15:0 of a write. While it holds 0xA05F it reads 0x0001A05F; otherwise it reads the stored 16 bits.
- R4: Writes to word 2 and word 7 update those registers only while word 5 holds 0xA05F. At any other time the write is dropped.
- R5: Word 3 stores only data bits 0 and 2, and reads back with all other bits zero. `led_o` follows bit 0. `remap_o` follows bit 2, where 1 selects RAM at address zero.
- R6: A write to word 3 with data bit 3 set raises `sys_rst_req_o` for exactly the one cycle after the write edge. Bit 3 always reads zero.
- R7: Writing word 12 ORs the data into the flags word, and writing word 13 clears the data's set bits in it. Words 14 and 15 do the same for the second flags word. Reads of words 12 and 14 return the two flags words.
- R8: Word 10 reads a CNT_W-bit counter, zero-extended to 32 bits. It advances by one on each cycle with `ref_tick_i` high, wraps modulo 2^CNT_W, and ignores writes.
- R9: A write to word 18 ORs bits into the IRQ enable, and a write to word 19 clears them. Word 18 reads the enable. Word 17 reads raw status, and word 16 reads raw AND enable. `irq_o` is high whenever raw AND enable is non-zero.
- R10: Words 24 to 27 behave as words 16 to 19 do, but for the FIQ enable and `fiq_o`.
- R11: Writes to word 20 set raw status bit 0 when data bit 0 is 1, and writes to word 21 clear it. Other data bits are ignored. Word 20 reads that bit alone.
- R12: A read of any word outside the readable set 0–5, 7–10, 12, 14, 16–18, 20, 24–26, 32–35 returns zero with `err_o` high. Readable words return with `err_o` low.
- R13: `rvalid_o`, `rdata_o` and `err_o` are valid in the cycle after the read request is sampled. `rdata_o` is zero whenever `rvalid_o` is low.
- R14: Words 8 and 9 store and return full 32-bit writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word index |
| wdata_i | input | 32 | Write data |
| ref_tick_i | input | 1 | Reference counter tick enable |
| rdata_o | output | 32 | Read data, one cycle after request |
| rvalid_o | output | 1 | Read data valid |
| err_o | output | 1 | Read of an unmapped word |
| led_o | output | 1 | LED drive (control bit 0) |
| remap_o | output | 1 | 1 = RAM at address zero (control bit 2) |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | IRQ level |
| fiq_o | output | 1 | FIQ level |

## Verification
Register writes, and the `led_o`, `remap_o`, `irq_o` and `fiq_o` levels that follow from them, are settled right after the edge that samples the write. The bench therefore samples them at the next falling edge. Read results appear one register stage later, at the falling edge after the request edge. The reset pulse is checked high at that same falling edge and low one cycle later. Counter results are read only after the bench's tick window has closed, so the expected count is simply the number of ticks modulo 256 for the 8-bit counter configuration used.

// File: rtl/cm_regs_pkg.sv
package cm_regs_pkg;
  localparam int W_ID      = 0;
  localparam int W_PROC    = 1;
  localparam int W_OSC     = 2;
  localparam int W_CTRL    = 3;
  localparam int W_STAT    = 4;
  localparam int W_LOCK    = 5;
  localparam int W_AUX     = 7;
  localparam int W_SDRAM   = 8;
  localparam int W_INIT    = 9;
  localparam int W_CNT     = 10;
  localparam int W_FLG_SET = 12;
  localparam int W_FLG_CLR = 13;
  localparam int W_NVF_SET = 14;
  localparam int W_NVF_CLR = 15;
  localparam int W_IRQ_ST  = 16;
  localparam int W_IRQ_RAW = 17;
  localparam int W_IRQ_ENS = 18;
  localparam int W_IRQ_ENC = 19;
  localparam int W_SWI_SET = 20;
  localparam int W_SWI_CLR = 21;
  localparam int W_FIQ_ST  = 24;
  localparam int W_FIQ_RAW = 25;
  localparam int W_FIQ_ENS = 26;
  localparam int W_FIQ_ENC = 27;
  localparam int W_VOLT_LO = 32;
  localparam int W_VOLT_HI = 35;

  localparam logic [31:0] ID_VAL    = 32'h411A_3001;
  localparam logic [31:0] STAT_VAL  = 32'h0010_0000;
  localparam logic [15:0] LOCK_KEY  = 16'hA05F;
  localparam logic [31:0] LOCK_OPEN = 32'h0001_A05F;
  localparam logic [31:0] OSC_RST   = 32'h0100_0048;
  localparam logic [31:0] AUX_RST   = 32'h0007_FEFF;
  localparam logic [31:0] SDRAM_RST = 32'h0001_1122;
  localparam logic [31:0] INIT_RST  = 32'h0000_0112;

  // indices into the set/clear register bank
  localparam int SC_FLG = 0;
  localparam int SC_NVF = 1;
  localparam int SC_IRQ = 2;
  localparam int SC_FIQ = 3;
  localparam int SC_NUM = 4;
endpackage

// File: rtl/cm_key_guard.sv
module cm_key_guard #(
  parameter int          DW      = 32,
  parameter int          KW      = 16,
  parameter logic [KW-1:0] KEY   = 16'hA05F,
  parameter logic [DW-1:0] A_RST = '0,
  parameter logic [DW-1:0] B_RST = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          key_we_i,
  input  logic          a_we_i,
  input  logic          b_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [KW-1:0] key_o,
  output logic          open_o,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o
);
  logic [KW-1:0] key_q;
  logic [DW-1:0] a_q, b_q;

  assign open_o = (key_q == KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      a_q   <= A_RST;
      b_q   <= B_RST;
    end else begin
      if (key_we_i)          key_q <= wdata_i[KW-1:0];
      if (a_we_i && open_o)  a_q   <= wdata_i;
      if (b_we_i && open_o)  b_q   <= wdata_i;
    end
  end

  assign key_o = key_q;
  assign a_o   = a_q;
  assign b_o   = b_q;
endmodule

// File: rtl/cm_setclr_reg.sv
module cm_setclr_reg #(
  parameter int           W   = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  logic [W-1:0] set_m, clr_m;

  assign set_m = set_i ? data_i : '0;
  assign clr_m = clr_i ? data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= RST;
    else         q <= (q | set_m) & ~clr_m;
  end

  assign q_o = q;
endmodule

// File: rtl/cm_ref_counter.sv
module cm_ref_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cm_ctrl_regs.sv
module cm_ctrl_regs
  import cm_regs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              ref_tick_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o,
  output logic              err_o,
  output logic              led_o,
  output logic              remap_o,
  output logic              sys_rst_req_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int DW = 32;

  int   idx;
  logic wr, rd;
  assign idx = int'(addr_i);
  assign wr  = req_i & we_i;
  assign rd  = req_i & ~we_i;

  // write strobes
  logic wr_lock, wr_osc, wr_aux, wr_ctrl, wr_sdram, wr_init, wr_swi_s, wr_swi_c;
  logic [SC_NUM-1:0] sc_set, sc_clr;

  always_comb begin
    wr_lock  = wr && idx == W_LOCK;
    wr_osc   = wr && idx == W_OSC;
    wr_aux   = wr && idx == W_AUX;
    wr_ctrl  = wr && idx == W_CTRL;
    wr_sdram = wr && idx == W_SDRAM;
    wr_init  = wr && idx == W_INIT;
    wr_swi_s = wr && idx == W_SWI_SET;
    wr_swi_c = wr && idx == W_SWI_CLR;
    sc_set[SC_FLG] = wr && idx == W_FLG_SET;
    sc_clr[SC_FLG] = wr && idx == W_FLG_CLR;
    sc_set[SC_NVF] = wr && idx == W_NVF_SET;
    sc_clr[SC_NVF] = wr && idx == W_NVF_CLR;
    sc_set[SC_IRQ] = wr && idx == W_IRQ_ENS;
    sc_clr[SC_IRQ] = wr && idx == W_IRQ_ENC;
    sc_set[SC_FIQ] = wr && idx == W_FIQ_ENS;
    sc_clr[SC_FIQ] = wr && idx == W_FIQ_ENC;
  end

  // lock-guarded oscillator words
  logic [15:0]   lock_val;
  logic          lock_open;
  logic [DW-1:0] osc_val, aux_val;

  cm_key_guard #(
    .DW(DW), .KW(16), .KEY(LOCK_KEY), .A_RST(OSC_RST), .B_RST(AUX_RST)
  ) u_guard (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .key_we_i(wr_lock), .a_we_i(wr_osc), .b_we_i(wr_aux),
    .wdata_i(wdata_i),
    .key_o(lock_val), .open_o(lock_open), .a_o(osc_val), .b_o(aux_val)
  );

  // set/clear bank: flags, nv flags, irq enable, fiq enable
  logic [DW-1:0] sc_q [SC_NUM];

  for (genvar g = 0; g < SC_NUM; g++) begin : g_sc
    cm_setclr_reg #(.W(DW)) u_sc (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_i(sc_set[g]), .clr_i(sc_clr[g]),
      .data_i(wdata_i), .q_o(sc_q[g])
    );
  end

  // software interrupt bit
  logic swi_q;
  cm_setclr_reg #(.W(1)) u_swi (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(wr_swi_s), .clr_i(wr_swi_c),
    .data_i(wdata_i[0]), .q_o(swi_q)
  );

  // reference counter
  logic [CNT_W-1:0] cnt_val;
  cm_ref_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(ref_tick_i), .cnt_o(cnt_val)
  );

  // control, plain storage, reset pulse
  logic          led_q, remap_q, rst_pulse_q;
  logic [DW-1:0] sdram_q, init_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      led_q       <= 1'b0;
      remap_q     <= 1'b0;
      rst_pulse_q <= 1'b0;
      sdram_q     <= SDRAM_RST;
      init_q      <= INIT_RST;
    end else begin
      rst_pulse_q <= wr_ctrl & wdata_i[3];
      if (wr_ctrl) begin
        led_q   <= wdata_i[0];
        remap_q <= wdata_i[2];
      end
      if (wr_sdram) sdram_q <= wdata_i;
      if (wr_init)  init_q  <= wdata_i;
    end
  end

  // interrupt levels
  logic [DW-1:0] raw;
  assign raw   = {{(DW-1){1'b0}}, swi_q};
  assign irq_o = |(raw & sc_q[SC_IRQ]);
  assign fiq_o = |(raw & sc_q[SC_FIQ]);

  // read mux
  logic [DW-1:0] rd_val;
  logic          rd_err;

  always_comb begin
    rd_val = '0;
    rd_err = 1'b0;
    case (idx) inside
      W_ID:                rd_val = ID_VAL;
      W_PROC:              rd_val = '0;
      W_OSC:               rd_val = osc_val;
      W_CTRL:              rd_val = {29'b0, remap_q, 1'b0, led_q};
      W_STAT:              rd_val = STAT_VAL;
      W_LOCK:              rd_val = lock_open ? LOCK_OPEN : {16'b0, lock_val};
      W_AUX:               rd_val = aux_val;
      W_SDRAM:             rd_val = sdram_q;
      W_INIT:              rd_val = init_q;
      W_CNT:               rd_val = DW'(cnt_val);
      W_FLG_SET:           rd_val = sc_q[SC_FLG];
      W_NVF_SET:           rd_val = sc_q[SC_NVF];
      W_IRQ_ST:            rd_val = raw & sc_q[SC_IRQ];
      W_IRQ_RAW:           rd_val = raw;
      W_IRQ_ENS:           rd_val = sc_q[SC_IRQ];
      W_SWI_SET:           rd_val = raw;
      W_FIQ_ST:            rd_val = raw & sc_q[SC_FIQ];
      W_FIQ_RAW:           rd_val = raw;
      W_FIQ_ENS:           rd_val = sc_q[SC_FIQ];
      [W_VOLT_LO:W_VOLT_HI]: rd_val = '0;
      default:             rd_err = 1'b1;
    endcase
  end

  logic [DW-1:0] rdata_q;
  logic          rvalid_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= rd;
      rdata_q  <= rd ? rd_val : '0;
      err_q    <= rd & rd_err;
    end
  end

  assign rdata_o       = rdata_q;
  assign rvalid_o      = rvalid_q;
  assign err_o         = err_q;
  assign led_o         = led_q;
  assign remap_o       = remap_q;
  assign sys_rst_req_o = rst_pulse_q;
endmodule

// File: rtl/cm_ctrl_regs_chk.sv
module cm_ctrl_regs_chk
  import cm_regs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              ref_tick_i,
  input logic [31:0]       rdata_o,
  input logic              rvalid_o,
  input logic              err_o,
  input logic              led_o,
  input logic              sys_rst_req_o,
  input logic [15:0]       lock_q,
  input logic [31:0]       osc_q,
  input logic [CNT_W-1:0]  cnt_q
);
  AST_RST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |=> !sys_rst_req_o); // R6

  AST_RST_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |-> $past(req_i && we_i && int'(addr_i) == W_CTRL && wdata_i[3])); // R6

  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i)); // R13

  AST_IDLE_DATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> rdata_o == 32'h0); // R13

  AST_ERR_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rvalid_o && rdata_o == 32'h0)); // R12

  AST_OSC_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && int'(addr_i) == W_OSC && lock_q != LOCK_KEY) |=> $stable(osc_q)); // R4

  AST_LED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && int'(addr_i) == W_CTRL) |=> $stable(led_o)); // R5

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_tick_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R8

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_tick_i |=> $stable(cnt_q)); // R8
endmodule

bind cm_ctrl_regs cm_ctrl_regs_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .ref_tick_i(ref_tick_i),
  .rdata_o(rdata_o), .rvalid_o(rvalid_o), .err_o(err_o), .led_o(led_o),
  .sys_rst_req_o(sys_rst_req_o), .lock_q(lock_val), .osc_q(osc_val),
  .cnt_q(cnt_val)
);

// File: tb/sim_cm_ctrl_regs.sv
module sim_cm_ctrl_regs;
  localparam int ADDR_W = 6;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req = 1'b0, we = 1'b0, tick = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              rvalid, err, led, remap, rst_req, irq, fiq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  cm_ctrl_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ref_tick_i(tick), .rdata_o(rdata), .rvalid_o(rvalid),
    .err_o(err), .led_o(led), .remap_o(remap), .sys_rst_req_o(rst_req),
    .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // write: visible at the falling edge after the sampling edge
  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  // read: registered result visible one falling edge later
  task automatic rd(input int a, output logic [31:0] d, output logic e, output logic v);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = ADDR_W'(a);
    @(negedge clk);
    d = rdata; e = err; v = rvalid;
    req = 1'b0;
  endtask

  task automatic rchk(input string tag, input int a, input logic [31:0] exp);
    logic [31:0] d; logic e, v;
    rd(a, d, e, v);
    chk(tag, d, exp);
  endtask

  function automatic bit mapped(input int i);
    return (i <= 5) || (i >= 7 && i <= 10) || i == 12 || i == 14 ||
           (i >= 16 && i <= 18) || i == 20 || (i >= 24 && i <= 26) ||
           (i >= 32 && i <= 35);
  endfunction

  function automatic logic [31:0] rst_val(input int i);
    case (i)
      0:       return 32'h411A3001;
      2:       return 32'h01000048;
      4:       return 32'h00100000;
      7:       return 32'h0007FEFF;
      8:       return 32'h00011122;
      9:       return 32'h00000112;
      default: return 32'h0;
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d; logic e, v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R2: outputs idle after reset
    chk("R2 outputs", {27'b0, led, remap, rst_req, irq, fiq}, 32'h0);

    // R2 R12 R1: sweep all words after reset
    for (int i = 0; i < (1 << ADDR_W); i++) begin
      rd(i, d, e, v);
      chk($sformatf("R2 word %0d", i), d, rst_val(i));
      chk($sformatf("R12 err word %0d", i), {31'b0, e}, {31'b0, !mapped(i)});
      chk($sformatf("R13 rvalid word %0d", i), {31'b0, v}, 32'h1);
    end
    chk("R13 idle rdata", rdata, 32'h0);

    // R1: constants ignore writes
    wr(0, 32'hFFFFFFFF); rchk("R1 id", 0, 32'h411A3001);
    wr(4, 32'h0);        rchk("R1 stat", 4, 32'h00100000);
    wr(1, 32'h55);       rchk("R1 word1", 1, 32'h0);
    for (int i = 32; i <= 35; i++) begin
      wr(i, 32'hA5A5A5A5);
      rchk($sformatf("R1 volt %0d", i), i, 32'h0);
    end

    // R3: lock storage and readback
    wr(5, 32'h1234A05F); rchk("R3 key", 5, 32'h0001A05F);
    wr(5, 32'hDEAD1111); rchk("R3 other", 5, 32'h00001111);

    // R4: guarded oscillator words
    wr(2, 32'hCAFE0000); rchk("R4 osc locked", 2, 32'h01000048);
    wr(7, 32'hCAFE0000); rchk("R4 aux locked", 7, 32'h0007FEFF);
    wr(5, 32'h0000A05F);
    wr(2, 32'h12345678); rchk("R4 osc open", 2, 32'h12345678);
    wr(7, 32'h0BADF00D); rchk("R4 aux open", 7, 32'h0BADF00D);
    wr(5, 32'h0);
    wr(7, 32'h0);        rchk("R4 aux relocked", 7, 32'h0BADF00D);

    // R5 R6: control word and reset pulse
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 3; wdata = 32'h0000000F;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk("R6 pulse high", {31'b0, rst_req}, 32'h1);
    chk("R5 led on", {31'b0, led}, 32'h1);
    chk("R5 remap on", {31'b0, remap}, 32'h1);
    @(negedge clk);
    chk("R6 pulse low", {31'b0, rst_req}, 32'h0);
    rchk("R5 R6 ctrl read", 3, 32'h00000005);
    wr(3, 32'hFFFFFFF2);
    chk("R6 no pulse", {31'b0, rst_req}, 32'h0);
    chk("R5 led off", {31'b0, led}, 32'h0);
    chk("R5 remap off", {31'b0, remap}, 32'h0);
    rchk("R5 ctrl read2", 3, 32'h0);
    wr(3, 32'h4);
    chk("R5 remap only", {30'b0, led, remap}, 32'h1);

    // R7: set/clear flags
    wr(12, 32'h0000F0F0);
    wr(13, 32'h000000F0); rchk("R7 flags", 12, 32'h0000F000);
    wr(14, 32'hAAAA5555);
    wr(15, 32'hFFFF0000); rchk("R7 nvflags", 14, 32'h00005555);
    rchk("R7 flags unaffected", 12, 32'h0000F000);

    // R14: plain storage
    wr(8, 32'hDEADBEEF); rchk("R14 sdram", 8, 32'hDEADBEEF);
    wr(9, 32'h00000003); rchk("R14 init", 9, 32'h00000003);

    // R11 R9 R10: interrupt section
    wr(20, 32'hFFFFFFFE); rchk("R11 bit0 only", 20, 32'h0);
    wr(20, 32'h00000001); rchk("R11 set", 20, 32'h1);
    rchk("R9 raw", 17, 32'h1);
    rchk("R9 masked", 16, 32'h0);
    chk("R9 irq off", {31'b0, irq}, 32'h0);
    wr(18, 32'h80000001); rchk("R9 enable", 18, 32'h80000001);
    chk("R9 irq on", {31'b0, irq}, 32'h1);
    rchk("R9 status", 16, 32'h1);
    wr(19, 32'h00000001); rchk("R9 enable clr", 18, 32'h80000000);
    chk("R9 irq cleared", {31'b0, irq}, 32'h0);
    wr(26, 32'h00000003); rchk("R10 enable", 26, 32'h3);
    chk("R10 fiq on", {31'b0, fiq}, 32'h1);
    rchk("R10 status", 24, 32'h1);
    rchk("R10 raw", 25, 32'h1);
    wr(27, 32'h00000001); rchk("R10 enable clr", 26, 32'h2);
    chk("R10 fiq off", {31'b0, fiq}, 32'h0);
    wr(26, 32'h1);
    wr(21, 32'hFFFFFFFE); rchk("R11 clr ignores high", 20, 32'h1);
    wr(21, 32'h00000001); rchk("R11 clr", 17, 32'h0);
    chk("R11 fiq drops", {31'b0, fiq}, 32'h0);

    // R8: counter with wrap on the 8-bit configuration
    rchk("R8 idle", 10, 32'h0);
    @(negedge clk); tick = 1'b1;
    repeat (300) @(negedge clk);
    tick = 1'b0;
    rchk("R8 wrap", 10, 32'(300 % 256));
    wr(10, 32'hFFFFFFFF); rchk("R8 write ignored", 10, 32'(300 % 256));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule